// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block produces the internal reset of a microcontroller core. It takes a digital supply-good flag from an analog power monitor, an oscillator activity signal and a watchdog trigger. Reset is held while power comes up. It is released only after three conditions have been met in order: the supply is good, the oscillator has been seen swinging both ways, and a stabilization count of clock periods has run out.

A drop of the supply-good flag forces reset again at once, with no clock edge needed. The sequencer then goes back to its first phase, so the whole release sequence runs again from the start. A watchdog trigger produces a fixed-length pulse on a separate external reset output. A two-bit phase output reports where the sequence stands.

Top module: `por_sequencer`

## Requirements
- R1: While rst_ni is low, core_rst_o is 1, phase_o is 0 and ext_rst_o is 0.
- R2: phase_o encodes 0 = waiting for supply, 1 = waiting for oscillator, 2 = stabilization count, 3 = running. core_rst_o is 1 in every phase except 3.
- R3: While supply_ok_i is low, phase_o stays 0 whatever osc_i does.
- R4: After supply_ok_i rises, phase_o changes from 0 to 1 on the third rising clock edge (two synchronizer stages plus the state register).
- R5: In phase 1 the sequencer moves on only after osc_i has shown both a rising and a falling transition since phase 1 was entered. A static level, or a single transition, keeps it in phase 1.
- R6: Phase 2 lasts exactly STAB_CYCLES (1024) clock periods. phase_o then becomes 3 and core_rst_o falls on that same rising clock edge.
- R7: A low supply_ok_i asserts core_rst_o and forces phase_o to 0 immediately, without a clock edge. The stabilization count is cleared, so a later release again takes the full STAB_CYCLES.
- R8: A rising edge on wdt_trig_i, sampled at a clock edge, drives ext_rst_o high from that edge for exactly PULSE_CYCLES (96) clock periods.
- R9: A trigger edge while ext_rst_o is already high is ignored and does not extend the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running core/reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-applied reset |
| supply_ok_i | input | 1 | Supply above safety level (asynchronous) |
| osc_i | input | 1 | Oscillator activity signal (asynchronous) |
| wdt_trig_i | input | 1 | Watchdog expiry trigger, rising-edge sensitive |
| core_rst_o | output | 1 | Internal reset, active high |
| ext_rst_o | output | 1 | External reset pulse, active high |
| phase_o | output | 2 | Current sequencer phase |

## Verification
The supply-loss response is due with no clock edge at all, so the bench samples it one time unit after dropping supply_ok_i, well before the next rising edge. Supply rise is due on the third rising edge. The bench therefore samples on falling edges and checks phase_o after two falling edges (still 0) and after three (now 1). The stabilization release is checked relative to the first falling edge that shows phase 2: phase 2 still holds after STAB_CYCLES-1 further falling edges, and phase 3 with reset released shows at the STAB_CYCLES-th. The watchdog pulse is counted sample by sample from the falling edge after the trigger: exactly 96 high samples, with the first one high and the output low afterwards, whether or not a second trigger arrives mid-pulse.

// File: rtl/por_pkg.sv
package por_pkg;

  typedef enum logic [1:0] {
    PH_WAIT_SUP = 2'd0,
    PH_WAIT_OSC = 2'd1,
    PH_COUNT    = 2'd2,
    PH_RUN      = 2'd3
  } phase_e;

endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sreg_q <= '0;
    else         sreg_q <= {sreg_q[STAGES-2:0], d_i};
  end

  assign q_o = sreg_q[STAGES-1];

endmodule

// File: rtl/por_osc_detect.sv
module por_osc_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic osc_i,
  output logic seen_o
);

  logic osc_s, osc_prev_q;
  logic seen_rise_q, seen_fall_q;

  por_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (osc_i),
    .q_o   (osc_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) osc_prev_q <= 1'b0;
    else         osc_prev_q <= osc_s;
  end

  // flags collect only while enabled; cleared otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_rise_q <= 1'b0;
      seen_fall_q <= 1'b0;
    end else if (!en_i) begin
      seen_rise_q <= 1'b0;
      seen_fall_q <= 1'b0;
    end else begin
      if (osc_s && !osc_prev_q) seen_rise_q <= 1'b1;
      if (!osc_s && osc_prev_q) seen_fall_q <= 1'b1;
    end
  end

  assign seen_o = seen_rise_q && seen_fall_q;

  p_rise_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_rise_q && en_i) |=> seen_rise_q);
  p_fall_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_fall_q && en_i) |=> seen_fall_q);

endmodule

// File: rtl/por_fsm.sv
module por_fsm
  import por_pkg::*;
#(
  parameter int STAB_CYCLES = 1024,
  localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sup_ok_i,
  input  logic   osc_seen_i,
  output phase_e phase_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYCLES - 1);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_WAIT_SUP: if (sup_ok_i) phase_d = PH_WAIT_OSC;
      PH_WAIT_OSC: if (osc_seen_i) begin
        phase_d = PH_COUNT;
        cnt_d   = '0;
      end
      PH_COUNT: begin
        if (cnt_q == CNT_LAST) phase_d = PH_RUN;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      PH_RUN: phase_d = PH_RUN;
      default: phase_d = PH_WAIT_SUP;
    endcase
  end

  // assertion asynchronous, release synchronous
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_WAIT_SUP;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;

  p_count_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WAIT_OSC && !osc_seen_i) |=> phase_q == PH_WAIT_OSC);
  p_release_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN && $past(phase_q) == PH_COUNT) |-> $past(cnt_q) == CNT_LAST);
  p_no_skip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WAIT_SUP) |=> (phase_q == PH_WAIT_SUP || phase_q == PH_WAIT_OSC));

endmodule

// File: rtl/por_wdt_pulse.sv
module por_wdt_pulse #(
  parameter int PULSE_CYCLES = 96,
  localparam int PW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);

  localparam logic [PW-1:0] P_LAST = PW'(PULSE_CYCLES - 1);

  logic          trig_q;
  logic          act_q;
  logic [PW-1:0] left_q;
  logic          start;

  assign start = trig_i && !trig_q && !act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      act_q  <= 1'b0;
      left_q <= '0;
    end else begin
      trig_q <= trig_i;
      if (start) begin
        act_q  <= 1'b1;
        left_q <= P_LAST;
      end else if (act_q) begin
        if (left_q == '0) act_q  <= 1'b0;
        else              left_q <= left_q - 1'b1;
      end
    end
  end

  assign pulse_o = act_q;

  // checker: length of the high run
  logic [PW:0] hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_len_q <= '0;
    else if (act_q)   hi_len_q <= hi_len_q + 1'b1;
    else              hi_len_q <= '0;
  end

  p_pulse_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> hi_len_q == (PW+1)'(PULSE_CYCLES));
  p_pulse_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> ($past(trig_i) && !$past(trig_q)));
  p_no_extend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && left_q != '0) |=> (act_q && left_q == $past(left_q) - 1'b1));

endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
  import por_pkg::*;
#(
  parameter int STAB_CYCLES  = 1024,
  parameter int PULSE_CYCLES = 96,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       osc_i,
  input  logic       wdt_trig_i,
  output logic       core_rst_o,
  output logic       ext_rst_o,
  output logic [1:0] phase_o
);

  logic   sup_rst_n;
  logic   sup_ok_s;
  logic   osc_seen;
  phase_e phase;

  // supply loss acts as an asynchronous clear on the whole sequence
  assign sup_rst_n = rst_ni & supply_ok_i;

  por_sync #(.STAGES(SYNC_STAGES)) u_sup_sync (
    .clk_i (clk_i),
    .rst_ni(sup_rst_n),
    .d_i   (1'b1),
    .q_o   (sup_ok_s)
  );

  por_osc_detect #(.SYNC_STAGES(SYNC_STAGES)) u_osc (
    .clk_i (clk_i),
    .rst_ni(sup_rst_n),
    .en_i  (phase == PH_WAIT_OSC),
    .osc_i (osc_i),
    .seen_o(osc_seen)
  );

  por_fsm #(.STAB_CYCLES(STAB_CYCLES)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (sup_rst_n),
    .sup_ok_i  (sup_ok_s),
    .osc_seen_i(osc_seen),
    .phase_o   (phase)
  );

  por_wdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_wdt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (wdt_trig_i),
    .pulse_o(ext_rst_o)
  );

  assign phase_o    = phase;
  assign core_rst_o = (phase != PH_RUN);

  p_supply_loss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> (core_rst_o && phase_o == 2'd0));
  p_no_sup_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supply_ok_i && !$past(supply_ok_i)) |-> phase_o == 2'd0);

endmodule

// File: tb/por_sequencer_tb.sv
module por_sequencer_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  STAB  = 1024;
  localparam int  PULSE = 96;

  logic clk = 1'b0;
  logic rst_n, supply_ok, osc, wdt_trig;
  logic core_rst, ext_rst;
  logic [1:0] phase;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  por_sequencer u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .supply_ok_i(supply_ok),
    .osc_i      (osc),
    .wdt_trig_i (wdt_trig),
    .core_rst_o (core_rst),
    .ext_rst_o  (ext_rst),
    .phase_o    (phase)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_phase(input logic [1:0] ph, input int limit, input string req);
    int k = 0;
    while (phase != ph && k < limit) begin
      @(negedge clk);
      k++;
    end
    chk(phase == ph, req, "phase reached", phase, ph);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(core_rst == 1'b1, "R1", "core_rst in reset", core_rst, 1);
    chk(phase == 2'd0, "R1", "phase in reset", phase, 0);
    chk(ext_rst == 1'b0, "R1", "ext_rst in reset", ext_rst, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_no_supply;
    for (int i = 0; i < 10; i++) begin
      osc = ~osc;
      repeat (3) @(negedge clk);
    end
    chk(phase == 2'd0, "R3", "phase without supply", phase, 0);
    chk(core_rst == 1'b1, "R3", "core_rst without supply", core_rst, 1);
  endtask

  task automatic t_supply_sync;
    supply_ok = 1'b1;
    repeat (2) @(negedge clk);
    chk(phase == 2'd0, "R4", "phase after 2 edges", phase, 0);
    @(negedge clk);
    chk(phase == 2'd1, "R4", "phase after 3 edges", phase, 1);
  endtask

  task automatic t_osc_gate;
    repeat (40) @(negedge clk);
    chk(phase == 2'd1, "R5", "static osc holds", phase, 1);
    chk(core_rst == 1'b1, "R2", "core_rst in phase 1", core_rst, 1);
    osc = 1'b1;
    repeat (20) @(negedge clk);
    chk(phase == 2'd1, "R5", "rise only holds", phase, 1);
    osc = 1'b0;
    wait_phase(2'd2, 20, "R5");
  endtask

  // entered on the first falling edge showing phase 2
  task automatic t_count(input string req);
    repeat (STAB - 1) @(negedge clk);
    chk(phase == 2'd2, req, "phase one before end", phase, 2);
    chk(core_rst == 1'b1, "R2", "core_rst while counting", core_rst, 1);
    @(negedge clk);
    chk(phase == 2'd3, req, "phase at end of count", phase, 3);
    chk(core_rst == 1'b0, req, "core_rst released", core_rst, 0);
  endtask

  task automatic bring_up;
    supply_ok = 1'b1;
    wait_phase(2'd1, 6, "R4");
    osc = 1'b1;
    repeat (5) @(negedge clk);
    osc = 1'b0;
    wait_phase(2'd2, 20, "R5");
  endtask

  task automatic t_supply_drop;
    @(negedge clk);
    supply_ok = 1'b0;
    #1;
    chk(core_rst == 1'b1, "R7", "core_rst at once from run", core_rst, 1);
    chk(phase == 2'd0, "R7", "phase at once from run", phase, 0);
    repeat (5) @(negedge clk);
    bring_up();
    repeat (500) @(negedge clk);
    supply_ok = 1'b0;
    #1;
    chk(core_rst == 1'b1, "R7", "core_rst at once from count", core_rst, 1);
    chk(phase == 2'd0, "R7", "phase at once from count", phase, 0);
    repeat (5) @(negedge clk);
    bring_up();
    t_count("R7");
  endtask

  task automatic t_wdt(input bit retrig);
    int hi = 0;
    bit first;
    @(negedge clk);
    wdt_trig = 1'b1;
    @(negedge clk);
    wdt_trig = 1'b0;
    first = ext_rst;
    for (int i = 1; i <= PULSE + 10; i++) begin
      if (ext_rst) hi++;
      if (retrig && i == 50) wdt_trig = 1'b1;
      if (retrig && i == 52) wdt_trig = 1'b0;
      @(negedge clk);
    end
    chk(first == 1'b1, retrig ? "R9" : "R8", "ext_rst first sample", first, 1);
    chk(hi == PULSE, retrig ? "R9" : "R8", "ext_rst high cycles", hi, PULSE);
    chk(ext_rst == 1'b0, retrig ? "R9" : "R8", "ext_rst after pulse", ext_rst, 0);
  endtask

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; osc = 1'b0; wdt_trig = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_no_supply();
    osc = 1'b0;
    @(negedge clk);
    t_supply_sync();
    t_osc_gate();
    t_count("R6");
    t_supply_drop();
    t_wdt(1'b0);
    t_wdt(1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule